// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sequences the operating states of a small 8-bit microcontroller core: normal run, idle and power-down. Software asks for a low-power state by writing two request bits. The block then gates the CPU clock, the peripheral clocks and the oscillator enable to match the state. Idle ends on any enabled interrupt or on a hardware reset. Power-down ends only on a hardware reset. The raw reset pin is qualified by counting consecutive oscillator clocks, so a short glitch cannot reset the chip.

While a low-power state is active, the block also tells the pad ring what to drive. The address-latch and program-fetch strobes are forced to a fixed level. Port 0 may be released to high impedance, and port 2 may be told to keep showing the fetch address or the port latch. These choices depend on whether code is fetched from on-chip or external program memory. When a reset pin edge wakes the core out of idle, the core runs briefly until the qualified reset arrives. During that wake window, writes to internal RAM are suppressed but port writes are not touched.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After `por_n` is released, the outputs hold these values: `mode_o` = 0 (run), `int_rst_o` = 0, all three clock enables = 1, and all five pin-override outputs = 0. Mode codes on `mode_o` are 0 = run, 1 = idle, 2 = power-down, 3 = wake window.
- R2: `int_rst_o` rises on the clock edge that samples `rst_pin_i` high for the 24th consecutive time. That count is 12 clocks per machine cycle times 2 machine cycles. Any edge that samples the pin low clears the count, and `int_rst_o` then falls on that same edge.
- R3: While `int_rst_o` is high, the next edge puts the block in run, and any mode write is ignored.
- R4: In run, a write with `pd_bit_i` = 1 selects power-down, whether or not `idle_bit_i` is also set. A write with only `idle_bit_i` = 1 selects idle. A write with neither bit leaves run unchanged. Mode writes made in any other state are ignored.
- R5: In idle, `irq_i` sampled high (with the reset pin low) returns the block to run on that edge.
- R6: Power-down ignores `irq_i` and is left only through `int_rst_o`. In power-down, `osc_en_o` equals `rst_pin_i` combinationally, so a reset pin can restart the oscillator.
- R7: `cpu_clk_en_o` is 1 only in run and in the wake window. `periph_clk_en_o` is 0 only in power-down.
- R8: In idle, `strobe_ovr_o` = 1 and `strobe_lvl_o` = 1. In power-down, `strobe_ovr_o` = 1 and `strobe_lvl_o` = 0. In the other states both outputs are 0.
- R9: When `ext_code_i` = 1:
  - `p0_hiz_o` = 1 in both idle and power-down;
  - `p2_addr_o` = 1 in idle only;
  - `p2_latch_o` = 1 in power-down only.

  When `ext_code_i` = 0, or in run or the wake window, all three are 0.
- R10: In idle, `rst_pin_i` sampled high moves the block to the wake window on that edge, taking precedence over `irq_i`. The wake window becomes run on the edge after `int_rst_o` rises, or on the edge that samples the pin low before qualification.
- R11: `ram_wr_ok_o` equals `ram_wr_i` in every state except the wake window, where it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Asynchronous power-on clear, active low |
| rst_pin_i | input | 1 | Raw hardware reset pin, active high |
| mode_wr_i | input | 1 | Strobe: control register holding the request bits is written |
| idle_bit_i | input | 1 | Idle request bit of that write |
| pd_bit_i | input | 1 | Power-down request bit of that write |
| irq_i | input | 1 | An enabled interrupt is pending |
| ext_code_i | input | 1 | 1 when code is fetched from external program memory |
| ram_wr_i | input | 1 | Core requests an internal RAM write |
| int_rst_o | output | 1 | Qualified internal reset |
| mode_o | output | 2 | Current mode code (see R1) |
| cpu_clk_en_o | output | 1 | CPU clock gate enable |
| periph_clk_en_o | output | 1 | Peripheral clock gate enable |
| osc_en_o | output | 1 | Oscillator enable |
| ram_wr_ok_o | output | 1 | Internal RAM write permitted |
| strobe_ovr_o | output | 1 | Address-latch and fetch strobes forced |
| strobe_lvl_o | output | 1 | Level forced on both strobes |
| p0_hiz_o | output | 1 | Port 0 released to high impedance |
| p2_addr_o | output | 1 | Port 2 keeps driving the fetch address |
| p2_latch_o | output | 1 | Port 2 drives its latch data |

## Verification
The hardest situation to reach is the wake window. It exists only when the reset pin rises while the core sleeps in idle. It then lasts exactly until the 24-edge qualifier fires, and the pin may also drop before that. The stimulus enters idle and raises the pin in the same cycle as an interrupt to prove the precedence. It holds a RAM write request across the whole window and samples the window's last cycle and the cycle after the reset fires. A separate run drops the pin after one edge to take the early exit.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

   typedef enum logic [1:0] {
      PM_RUN  = 2'd0,
      PM_IDLE = 2'd1,
      PM_DOWN = 2'd2,
      PM_WAKE = 2'd3
   } pm_state_e;

   typedef struct packed {
      logic strobe_ovr;
      logic strobe_lvl;
      logic p0_hiz;
      logic p2_addr;
      logic p2_latch;
   } pin_ovr_t;

   localparam int unsigned PIN_OVR_W = $bits(pin_ovr_t);

endpackage

// File: rtl/pdc_rst_qual.sv
module pdc_rst_qual #(
   parameter int unsigned OSC_PER_MC  = 12,
   parameter int unsigned RST_MCYCLES = 2,
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic por_n,
   input  logic rst_pin_i,
   output logic pin_hi_o,
   output logic int_rst_o
);

   localparam int unsigned LIMIT = OSC_PER_MC * RST_MCYCLES;
   localparam int unsigned CNT_W = $clog2(LIMIT + 1);
   localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(LIMIT);

   logic             pin_s;
   logic [CNT_W-1:0] hi_cnt;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign pin_s = rst_pin_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sh;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
               sh <= '0;
            end else begin
               sh[0] <= rst_pin_i;
               for (int i = 1; i < SYNC_STAGES; i++) begin
                  sh[i] <= sh[i-1];
               end
            end
         end
         assign pin_s = sh[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         hi_cnt <= '0;
      end else if (!pin_s) begin
         hi_cnt <= '0;
      end else if (hi_cnt != LIMIT_C) begin
         hi_cnt <= hi_cnt + 1'b1;
      end
   end

   assign pin_hi_o  = pin_s;
   assign int_rst_o = (hi_cnt == LIMIT_C);

endmodule

// File: rtl/pdc_mode_fsm.sv
module pdc_mode_fsm
   import pdc_pkg::*;
(
   input  logic      clk,
   input  logic      por_n,
   input  logic      int_rst_i,
   input  logic      pin_hi_i,
   input  logic      pin_raw_i,
   input  logic      mode_wr_i,
   input  logic      idle_bit_i,
   input  logic      pd_bit_i,
   input  logic      irq_i,
   input  logic      ram_wr_i,
   output pm_state_e state_o,
   output logic      cpu_clk_en_o,
   output logic      periph_clk_en_o,
   output logic      osc_en_o,
   output logic      ram_wr_ok_o
);

   pm_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      if (int_rst_i) begin
         st_d = PM_RUN;
      end else begin
         unique case (st_q)
            PM_RUN: begin
               if (mode_wr_i && pd_bit_i)        st_d = PM_DOWN;
               else if (mode_wr_i && idle_bit_i) st_d = PM_IDLE;
            end
            PM_IDLE: begin
               if (pin_hi_i)   st_d = PM_WAKE;
               else if (irq_i) st_d = PM_RUN;
            end
            PM_DOWN: st_d = PM_DOWN;
            PM_WAKE: begin
               if (!pin_hi_i) st_d = PM_RUN;
            end
            default: st_d = PM_RUN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) st_q <= PM_RUN;
      else        st_q <= st_d;
   end

   assign state_o         = st_q;
   assign cpu_clk_en_o    = (st_q == PM_RUN) || (st_q == PM_WAKE);
   assign periph_clk_en_o = (st_q != PM_DOWN);
   assign osc_en_o        = (st_q != PM_DOWN) || pin_raw_i;
   assign ram_wr_ok_o     = ram_wr_i && (st_q != PM_WAKE);

endmodule

// File: rtl/pdc_pin_ovr.sv
module pdc_pin_ovr
   import pdc_pkg::*;
(
   input  pm_state_e state_i,
   input  logic      ext_code_i,
   output pin_ovr_t  ovr_o
);

   always_comb begin
      ovr_o = '0;
      unique case (state_i)
         PM_IDLE: begin
            ovr_o.strobe_ovr = 1'b1;
            ovr_o.strobe_lvl = 1'b1;
            ovr_o.p0_hiz     = ext_code_i;
            ovr_o.p2_addr    = ext_code_i;
         end
         PM_DOWN: begin
            ovr_o.strobe_ovr = 1'b1;
            ovr_o.strobe_lvl = 1'b0;
            ovr_o.p0_hiz     = ext_code_i;
            ovr_o.p2_latch   = ext_code_i;
         end
         default: ovr_o = '0;
      endcase
   end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
   import pdc_pkg::*;
#(
   parameter int unsigned OSC_PER_MC  = 12,
   parameter int unsigned RST_MCYCLES = 2,
   parameter int unsigned SYNC_STAGES = 0,
   parameter bit          REG_OVR     = 1'b0
) (
   input  logic       clk,
   input  logic       por_n,
   input  logic       rst_pin_i,
   input  logic       mode_wr_i,
   input  logic       idle_bit_i,
   input  logic       pd_bit_i,
   input  logic       irq_i,
   input  logic       ext_code_i,
   input  logic       ram_wr_i,
   output logic       int_rst_o,
   output logic [1:0] mode_o,
   output logic       cpu_clk_en_o,
   output logic       periph_clk_en_o,
   output logic       osc_en_o,
   output logic       ram_wr_ok_o,
   output logic       strobe_ovr_o,
   output logic       strobe_lvl_o,
   output logic       p0_hiz_o,
   output logic       p2_addr_o,
   output logic       p2_latch_o
);

   generate
      if (OSC_PER_MC < 1) begin : g_bad_mc
         $error("OSC_PER_MC must be at least 1");
      end
      if (RST_MCYCLES < 1) begin : g_bad_rc
         $error("RST_MCYCLES must be at least 1");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must not exceed 4");
      end
   endgenerate

   logic      pin_hi;
   logic      int_rst;
   pm_state_e state;
   pin_ovr_t  ovr_c;
   pin_ovr_t  ovr_out;

   pdc_rst_qual #(
      .OSC_PER_MC (OSC_PER_MC),
      .RST_MCYCLES(RST_MCYCLES),
      .SYNC_STAGES(SYNC_STAGES)
   ) u_qual (
      .clk      (clk),
      .por_n    (por_n),
      .rst_pin_i(rst_pin_i),
      .pin_hi_o (pin_hi),
      .int_rst_o(int_rst)
   );

   pdc_mode_fsm u_fsm (
      .clk            (clk),
      .por_n          (por_n),
      .int_rst_i      (int_rst),
      .pin_hi_i       (pin_hi),
      .pin_raw_i      (rst_pin_i),
      .mode_wr_i      (mode_wr_i),
      .idle_bit_i     (idle_bit_i),
      .pd_bit_i       (pd_bit_i),
      .irq_i          (irq_i),
      .ram_wr_i       (ram_wr_i),
      .state_o        (state),
      .cpu_clk_en_o   (cpu_clk_en_o),
      .periph_clk_en_o(periph_clk_en_o),
      .osc_en_o       (osc_en_o),
      .ram_wr_ok_o    (ram_wr_ok_o)
   );

   pdc_pin_ovr u_ovr (
      .state_i   (state),
      .ext_code_i(ext_code_i),
      .ovr_o     (ovr_c)
   );

   generate
      if (REG_OVR) begin : g_ovr_reg
         pin_ovr_t ovr_q;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) ovr_q <= '0;
            else        ovr_q <= ovr_c;
         end
         assign ovr_out = ovr_q;
      end else begin : g_ovr_comb
         assign ovr_out = ovr_c;
      end
   endgenerate

   assign int_rst_o    = int_rst;
   assign mode_o       = state;
   assign strobe_ovr_o = ovr_out.strobe_ovr;
   assign strobe_lvl_o = ovr_out.strobe_lvl;
   assign p0_hiz_o     = ovr_out.p0_hiz;
   assign p2_addr_o    = ovr_out.p2_addr;
   assign p2_latch_o   = ovr_out.p2_latch;

endmodule

// File: rtl/pdc_checker.sv
module pdc_checker #(
   parameter int unsigned OSC_PER_MC  = 12,
   parameter int unsigned RST_MCYCLES = 2,
   parameter int unsigned SYNC_STAGES = 0,
   parameter bit          REG_OVR     = 1'b0
) (
   input logic       clk,
   input logic       por_n,
   input logic       rst_pin_i,
   input logic       irq_i,
   input logic       int_rst_o,
   input logic [1:0] mode_o,
   input logic       cpu_clk_en_o,
   input logic       periph_clk_en_o,
   input logic       ram_wr_ok_o,
   input logic       strobe_ovr_o,
   input logic       strobe_lvl_o
);

   localparam int unsigned LIMIT = OSC_PER_MC * RST_MCYCLES;
   localparam int unsigned CNT_W = $clog2(LIMIT + 1);
   localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(LIMIT);

   logic [CNT_W-1:0] raw_hi;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                raw_hi <= '0;
      else if (!rst_pin_i)       raw_hi <= '0;
      else if (raw_hi != LIMIT_C) raw_hi <= raw_hi + 1'b1;
   end

   // R2: no qualified reset before the pin has been high for the full window
   a_r2_no_early_reset: assert property (@(posedge clk) disable iff (!por_n)
      (raw_hi != LIMIT_C) |-> !int_rst_o);

   // R3: qualified reset returns the block to run
   a_r3_reset_to_run: assert property (@(posedge clk) disable iff (!por_n)
      int_rst_o |=> (mode_o == 2'd0));

   // R6: power-down is held until reset
   a_r6_down_holds: assert property (@(posedge clk) disable iff (!por_n)
      ((mode_o == 2'd2) && !int_rst_o) |=> (mode_o == 2'd2));

   // R7: CPU clock stopped in both low-power states
   a_r7_cpu_gated: assert property (@(posedge clk) disable iff (!por_n)
      ((mode_o == 2'd1) || (mode_o == 2'd2)) |-> !cpu_clk_en_o);

   // R7: peripheral clocks only stop in power-down
   a_r7_periph_gated: assert property (@(posedge clk) disable iff (!por_n)
      (mode_o != 2'd2) |-> periph_clk_en_o);

   // R11: RAM writes suppressed in the wake window
   a_r11_ram_blocked: assert property (@(posedge clk) disable iff (!por_n)
      (mode_o == 2'd3) |-> !ram_wr_ok_o);

   generate
      if (SYNC_STAGES == 0) begin : g_r5
         // R5: interrupt leaves idle
         a_r5_irq_wakes: assert property (@(posedge clk) disable iff (!por_n)
            ((mode_o == 2'd1) && irq_i && !rst_pin_i && !int_rst_o) |=> (mode_o == 2'd0));
      end
      if (!REG_OVR) begin : g_r8
         // R8: strobes forced high in idle
         a_r8_idle_strobe: assert property (@(posedge clk) disable iff (!por_n)
            (mode_o == 2'd1) |-> (strobe_ovr_o && strobe_lvl_o));
      end
   endgenerate

endmodule

bind pwr_mode_ctrl pdc_checker #(
   .OSC_PER_MC (OSC_PER_MC),
   .RST_MCYCLES(RST_MCYCLES),
   .SYNC_STAGES(SYNC_STAGES),
   .REG_OVR    (REG_OVR)
) u_chk (
   .clk            (clk),
   .por_n          (por_n),
   .rst_pin_i      (rst_pin_i),
   .irq_i          (irq_i),
   .int_rst_o      (int_rst_o),
   .mode_o         (mode_o),
   .cpu_clk_en_o   (cpu_clk_en_o),
   .periph_clk_en_o(periph_clk_en_o),
   .ram_wr_ok_o    (ram_wr_ok_o),
   .strobe_ovr_o   (strobe_ovr_o),
   .strobe_lvl_o   (strobe_lvl_o)
);

// File: tb/pwr_mode_ctrl_test.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_test;

   logic       clk = 1'b0;
   logic       por_n, rst_pin, mode_wr, idle_bit, pd_bit, irq, ext_code, ram_wr;
   logic       int_rst, cpu_en, per_en, osc_en, ram_ok;
   logic       s_ovr, s_lvl, p0z, p2a, p2l;
   logic [1:0] mode;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   pwr_mode_ctrl uut (
      .clk(clk), .por_n(por_n), .rst_pin_i(rst_pin), .mode_wr_i(mode_wr),
      .idle_bit_i(idle_bit), .pd_bit_i(pd_bit), .irq_i(irq), .ext_code_i(ext_code),
      .ram_wr_i(ram_wr), .int_rst_o(int_rst), .mode_o(mode), .cpu_clk_en_o(cpu_en),
      .periph_clk_en_o(per_en), .osc_en_o(osc_en), .ram_wr_ok_o(ram_ok),
      .strobe_ovr_o(s_ovr), .strobe_lvl_o(s_lvl), .p0_hiz_o(p0z),
      .p2_addr_o(p2a), .p2_latch_o(p2l)
   );

   // [12]pd [11]idle [10]ext [9:8]mode [7]s_ovr [6]s_lvl [5]p0z [4]p2a [3]p2l [2]cpu [1]per [0]osc
   localparam logic [12:0] VEC [8] = '{
      13'b0_0_0_00_00000_111,
      13'b0_0_1_00_00000_111,
      13'b0_1_0_01_11000_011,
      13'b0_1_1_01_11110_011,
      13'b1_0_0_10_10000_000,
      13'b1_0_1_10_10101_000,
      13'b1_1_0_10_10000_000,
      13'b1_1_1_10_10101_000
   };

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic req(input logic pd, input logic idl);
      mode_wr = 1'b1; pd_bit = pd; idle_bit = idl;
      step();
      mode_wr = 1'b0; pd_bit = 1'b0; idle_bit = 1'b0;
   endtask

   task automatic reset_pulse();
      rst_pin = 1'b1;
      repeat (24) step();
      rst_pin = 1'b0;
      step();
   endtask

   initial begin
      por_n = 0; rst_pin = 0; mode_wr = 0; idle_bit = 0; pd_bit = 0;
      irq = 0; ext_code = 0; ram_wr = 0;
      repeat (3) step();
      por_n = 1;
      step();
      chk("R1 mode", 16'(mode), 16'd0);
      chk("R1 int_rst", 16'(int_rst), 16'd0);
      chk("R1 clocks", 16'({cpu_en, per_en, osc_en}), 16'h7);
      chk("R1 overrides", 16'({s_ovr, s_lvl, p0z, p2a, p2l}), 16'h0);

      // R2: 23 high edges do not reset, the 24th does
      rst_pin = 1;
      repeat (23) step();
      chk("R2 before window", 16'(int_rst), 16'd0);
      step();
      chk("R2 at window", 16'(int_rst), 16'd1);
      // R3: write ignored while reset active
      mode_wr = 1; pd_bit = 1;
      step();
      mode_wr = 0; pd_bit = 0;
      chk("R3 write ignored", 16'(mode), 16'd0);
      rst_pin = 0;
      step();
      chk("R2 release", 16'(int_rst), 16'd0);

      // R2: interrupted pulse restarts the count
      rst_pin = 1;
      repeat (10) step();
      rst_pin = 0;
      step();
      rst_pin = 1;
      repeat (23) step();
      chk("R2 restart count", 16'(int_rst), 16'd0);
      rst_pin = 0;
      step();

      // R4 R7 R8 R9: request table
      foreach (VEC[i]) begin
         ext_code = VEC[i][10];
         req(VEC[i][12], VEC[i][11]);
         chk($sformatf("R4 mode vec%0d", i), 16'(mode), 16'(VEC[i][9:8]));
         chk($sformatf("R8 R9 pins vec%0d", i), 16'({s_ovr, s_lvl, p0z, p2a, p2l}),
             16'(VEC[i][7:3]));
         chk($sformatf("R7 clocks vec%0d", i), 16'({cpu_en, per_en, osc_en}),
             16'(VEC[i][2:0]));
         reset_pulse();
      end
      ext_code = 0;

      // R5: interrupt leaves idle; R4: write in idle ignored; R11 in idle
      req(1'b0, 1'b1);
      req(1'b1, 1'b0);
      chk("R4 idle ignores write", 16'(mode), 16'd1);
      ram_wr = 1;
      #0.5;
      chk("R11 ram ok in idle", 16'(ram_ok), 16'd1);
      ram_wr = 0;
      irq = 1;
      step();
      irq = 0;
      chk("R5 irq exits idle", 16'(mode), 16'd0);

      // R6: power-down ignores irq, osc follows pin, reset exits
      req(1'b1, 1'b0);
      irq = 1;
      repeat (5) step();
      irq = 0;
      chk("R6 irq ignored", 16'(mode), 16'd2);
      chk("R6 osc off", 16'(osc_en), 16'd0);
      rst_pin = 1;
      #0.5;
      chk("R6 osc restart", 16'(osc_en), 16'd1);
      repeat (24) step();
      rst_pin = 0;
      step();
      chk("R6 reset exits down", 16'(mode), 16'd0);

      // R10 R11: wake window
      req(1'b0, 1'b1);
      ram_wr = 1; irq = 1; rst_pin = 1;
      step();
      irq = 0;
      chk("R10 wake over irq", 16'(mode), 16'd3);
      chk("R10 cpu runs", 16'(cpu_en), 16'd1);
      chk("R11 ram blocked", 16'(ram_ok), 16'd0);
      repeat (22) step();
      chk("R10 window edge23", 16'({mode, ram_ok}), 16'({2'd3, 1'b0}));
      step();
      chk("R10 reset fires edge24", 16'({int_rst, mode}), 16'({1'b1, 2'd3}));
      step();
      chk("R10 run after reset", 16'(mode), 16'd0);
      chk("R11 ram ok in run", 16'(ram_ok), 16'd1);
      rst_pin = 0; ram_wr = 0;
      step();

      // R10: pin drops early
      req(1'b0, 1'b1);
      rst_pin = 1;
      step();
      chk("R10 glitch wake", 16'(mode), 16'd3);
      rst_pin = 0;
      step();
      chk("R10 glitch exit", 16'(mode), 16'd0);
      chk("R10 no reset", 16'(int_rst), 16'd0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog R1 actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule